// File: doc/BRIEF.md
# Serial Divider-Setting Loader

This block receives divider settings for a frequency synthesizer over a three-wire serial link: a data line, a serial clock and a load strobe. Each rising edge of the serial clock pushes one bit into a shift register. While the load strobe is high, the word in the shift register is copied into one of two holding registers. The last bit of the word, the routing bit, picks which one.

A routing bit of 1 marks a 16-bit reference word. It carries a 14-bit reference ratio, sent LSB first, then a prescaler-select bit. A routing bit of 0 marks a 19-bit main word. It carries a 7-bit swallow count, then an 11-bit main count, each sent LSB first. The holding registers drive the divider settings straight to the rest of the synthesizer. Three flag outputs mark settings that fall outside the usable range.

All three serial lines are sampled on the system clock `clk`. They are assumed to be already synchronous to it and free of bounce. A serial-clock edge is seen as a low sample followed by a high sample.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset, all setting outputs are zero. The shift register holds zeros. `ref_ratio_low`, `main_count_low` and `swallow_not_below_count` all read 1.
- R2: Exactly one bit moves into the shift register for each low-to-high change of `ser_clk` seen on `clk`. The bit is the value of `ser_data` at that `clk` edge. Holding `ser_clk` high for several cycles, or letting it fall, shifts nothing.
- R3: Routing is decided only by the most recently shifted bit. Any number of earlier bits may come before a word: bits older than the 19 most recent ones are discarded.
- R4: With routing bit 1, a load fills the reference register. Of the last 16 bits shifted, the first 14 are `ref_ratio` (LSB first), the 15th is `ref_presc_sel` and the 16th is the routing bit. The main outputs do not change.
- R5: With routing bit 0, a load fills the main register. Of the last 19 bits shifted, the first 7 are `main_swallow` (LSB first), the next 11 are `main_count` (LSB first) and the 19th is the routing bit. The reference outputs do not change.
- R6: A transfer happens on every `clk` edge at which `ser_load` is high. The new setting is visible on the outputs after that edge.
- R7: While `ser_load` is low, all setting outputs hold their values, whatever the serial clock and data do.
- R8: When a serial-clock rise and a high `ser_load` fall on the same `clk` edge, the register captures the word as it was before that bit was shifted.
- R9: If `ser_load` stays high, a transfer happens on each following `clk` edge.
- R10: `ref_ratio_low` is 1 exactly when `ref_ratio` < 8. `main_count_low` is 1 exactly when `main_count` < 16. `swallow_not_below_count` is 1 exactly when `main_swallow` >= `main_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; a rise shifts one bit |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; while high the word is transferred |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_presc_sel | output | 1 | Prescaler ratio select bit |
| main_swallow | output | 7 | Swallow count (A) |
| main_count | output | 11 | Main programmable count (N) |
| ref_ratio_low | output | 1 | Reference ratio below 8 |
| main_count_low | output | 1 | Main count below 16 |
| swallow_not_below_count | output | 1 | Swallow count not smaller than main count |

## Verification
A shift and a transfer can land on the same `clk` edge. This happens when the bench raises `ser_clk` and `ser_load` together on a negative edge, right after a complete reference word. The ratio read one cycle later must be that complete word, not the word moved along by one bit. A behavioural model built on a bit queue applies the load before the shift on every edge, so every cycle of the run judges this order as well.

// File: rtl/sload_pkg.sv
// Package: shared types and helpers for the serial divider-setting loader.
// Assumes nothing beyond IEEE 1800-2017 elaboration-time evaluation.
package sload_pkg;

    // Destination selected by the routing bit of a serial word.
    typedef enum logic {
        DEST_MAIN = 1'b0,
        DEST_REF  = 1'b1
    } dest_e;

    // Larger of two widths, used to size the shared shift register.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sload_edge_detect.sv
// Rise detector: pulses 'rise' for one clk cycle when 'sig' goes from a low
// sample to a high sample. Assumes 'sig' is already synchronous to clk.
module sload_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Remember the previous sample of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // A rise is a high sample whose previous sample was low.
    assign rise = sig & ~sig_q;
endmodule

// File: rtl/sload_shifter.sv
// Serial shift register: each enabled cycle, the new bit enters at the top
// (the routing-bit position) and older bits move down toward bit 0. Bits
// that fall off bit 0 are lost. Assumes shift_en lasts one cycle per bit.
module sload_shifter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Move the word down one place and insert the new bit at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {din, q[W-1:1]};
    end
endmodule

// File: rtl/sload_router.sv
// Router and holding registers: while 'load' is high, decode the routing bit
// at the top of the word and copy the matching fields into the reference or
// the main register. Field positions follow from LSB-first framing that ends
// at the top bit. Assumes SR_W is at least the longer of the two word lengths.
module sload_router
    import sload_pkg::*;
#(
    parameter int SR_W  = 19,
    parameter int REF_W = 14,
    parameter int A_W   = 7,
    parameter int N_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SR_W-1:0]  word,
    output logic [REF_W-1:0] ref_ratio,
    output logic             ref_presc,
    output logic [A_W-1:0]   main_a,
    output logic [N_W-1:0]   main_n
);
    localparam int CTRL_POS  = SR_W - 1;
    localparam int PRESC_POS = SR_W - 2;
    localparam int REF_LSB   = SR_W - REF_W - 2;
    localparam int A_LSB     = SR_W - A_W - N_W - 1;
    localparam int N_LSB     = A_LSB + A_W;

    dest_e dest;
    logic  load_ref;
    logic  load_main;

    // Decode the destination from the most recently shifted bit.
    always_comb begin
        dest      = dest_e'(word[CTRL_POS]);
        load_ref  = load && (dest == DEST_REF);
        load_main = load && (dest == DEST_MAIN);
    end

    // Reference holding register: ratio and prescaler select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ratio <= '0;
            ref_presc <= 1'b0;
        end else if (load_ref) begin
            ref_ratio <= word[REF_LSB +: REF_W];
            ref_presc <= word[PRESC_POS];
        end
    end

    // Main holding register: swallow count and main count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_a <= '0;
            main_n <= '0;
        end else if (load_main) begin
            main_a <= word[A_LSB +: A_W];
            main_n <= word[N_LSB +: N_W];
        end
    end
endmodule

// File: rtl/sload_range_flags.sv
// Range flags: combinational checks of the held settings against the minimum
// ratio, the minimum main count and the swallow-below-count rule. Assumes
// REF_MIN fits in REF_W bits and N_MIN fits in N_W bits.
module sload_range_flags
    import sload_pkg::*;
#(
    parameter int REF_W   = 14,
    parameter int A_W     = 7,
    parameter int N_W     = 11,
    parameter int REF_MIN = 8,
    parameter int N_MIN   = 16
) (
    input  logic [REF_W-1:0] ref_ratio,
    input  logic [A_W-1:0]   main_a,
    input  logic [N_W-1:0]   main_n,
    output logic             ratio_low,
    output logic             count_low,
    output logic             a_not_below_n
);
    localparam int CMP_W = max_of(A_W, N_W);

    logic [CMP_W-1:0] a_ext;
    logic [CMP_W-1:0] n_ext;

    // Widen both counts to a common width before comparing.
    generate
        if (A_W < CMP_W) begin : g_pad_a
            assign a_ext = {{(CMP_W-A_W){1'b0}}, main_a};
        end else begin : g_keep_a
            assign a_ext = main_a;
        end
        if (N_W < CMP_W) begin : g_pad_n
            assign n_ext = {{(CMP_W-N_W){1'b0}}, main_n};
        end else begin : g_keep_n
            assign n_ext = main_n;
        end
    endgenerate

    // Compare the settings against their limits.
    always_comb begin
        ratio_low     = ref_ratio < REF_W'(REF_MIN);
        count_low     = main_n < N_W'(N_MIN);
        a_not_below_n = a_ext >= n_ext;
    end
endmodule

// File: rtl/synth_serial_loader.sv
// Top: serial divider-setting loader. Finds serial-clock rises, shifts the
// data into a register as long as the longer word, routes the word to the
// reference or main register while the load strobe is high, and flags
// out-of-range settings. Assumes all serial lines are synchronous to clk.
module synth_serial_loader
    import sload_pkg::*;
#(
    parameter int REF_W   = 14,
    parameter int A_W     = 7,
    parameter int N_W     = 11,
    parameter int REF_MIN = 8,
    parameter int N_MIN   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_load,
    output logic [REF_W-1:0] ref_ratio,
    output logic             ref_presc_sel,
    output logic [A_W-1:0]   main_swallow,
    output logic [N_W-1:0]   main_count,
    output logic             ref_ratio_low,
    output logic             main_count_low,
    output logic             swallow_not_below_count
);
    localparam int REF_WORD  = REF_W + 2;
    localparam int MAIN_WORD = A_W + N_W + 1;
    localparam int SR_W      = max_of(REF_WORD, MAIN_WORD);

    logic            shift_rise;
    logic [SR_W-1:0] shift_q;

    // Find serial-clock rises.
    sload_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (ser_clk),
        .rise  (shift_rise)
    );

    // Collect serial bits.
    sload_shifter #(.W(SR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_rise),
        .din      (ser_data),
        .q        (shift_q)
    );

    // Route the word to its holding register.
    sload_router #(
        .SR_W  (SR_W),
        .REF_W (REF_W),
        .A_W   (A_W),
        .N_W   (N_W)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .word      (shift_q),
        .ref_ratio (ref_ratio),
        .ref_presc (ref_presc_sel),
        .main_a    (main_swallow),
        .main_n    (main_count)
    );

    // Flag out-of-range settings.
    sload_range_flags #(
        .REF_W   (REF_W),
        .A_W     (A_W),
        .N_W     (N_W),
        .REF_MIN (REF_MIN),
        .N_MIN   (N_MIN)
    ) u_flags (
        .ref_ratio     (ref_ratio),
        .main_a        (main_swallow),
        .main_n        (main_count),
        .ratio_low     (ref_ratio_low),
        .count_low     (main_count_low),
        .a_not_below_n (swallow_not_below_count)
    );
endmodule

// File: rtl/synth_serial_loader_chk.sv
// Checker: temporal properties of shifting, routing and holding, bound into
// the top module. Assumes the same field layout as the router.
module synth_serial_loader_chk #(
    parameter int SR_W  = 19,
    parameter int REF_W = 14,
    parameter int A_W   = 7,
    parameter int N_W   = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_data,
    input logic             ser_load,
    input logic             shift_rise,
    input logic [SR_W-1:0]  shift_q,
    input logic [REF_W-1:0] ref_ratio,
    input logic             ref_presc_sel,
    input logic [A_W-1:0]   main_swallow,
    input logic [N_W-1:0]   main_count
);
    localparam int TOP     = SR_W - 1;
    localparam int REF_LSB = SR_W - REF_W - 2;
    localparam int A_LSB   = SR_W - A_W - N_W - 1;

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_rise |=> (shift_q[TOP-1:0] == $past(shift_q[TOP:1]))
                       && (shift_q[TOP] == $past(ser_data)));

    // R2
    no_idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_rise |=> $stable(shift_q));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load |=> $stable(ref_ratio) && $stable(ref_presc_sel)
                      && $stable(main_swallow) && $stable(main_count));

    // R4
    ref_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load && shift_q[TOP]) |=>
            (ref_ratio == $past(shift_q[REF_LSB +: REF_W]))
            && (ref_presc_sel == $past(shift_q[TOP-1]))
            && $stable(main_swallow) && $stable(main_count));

    // R5
    main_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load && !shift_q[TOP]) |=>
            (main_swallow == $past(shift_q[A_LSB +: A_W]))
            && (main_count == $past(shift_q[A_LSB + A_W +: N_W]))
            && $stable(ref_ratio) && $stable(ref_presc_sel));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(
    .SR_W  (SR_W),
    .REF_W (REF_W),
    .A_W   (A_W),
    .N_W   (N_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_data      (ser_data),
    .ser_load      (ser_load),
    .shift_rise    (shift_rise),
    .shift_q       (shift_q),
    .ref_ratio     (ref_ratio),
    .ref_presc_sel (ref_presc_sel),
    .main_swallow  (main_swallow),
    .main_count    (main_count)
);

// File: tb/synth_serial_loader_tb_top.sv
// Bench: directed serial sequences plus a queue-based behavioural model that
// is compared with the outputs on every falling clock edge.
module synth_serial_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;
    logic [13:0] ref_ratio;
    logic ref_presc_sel;
    logic [6:0] main_swallow;
    logic [10:0] main_count;
    logic ref_ratio_low, main_count_low, swallow_not_below_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    synth_serial_loader dut_i (
        .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_data (ser_data),
        .ser_load (ser_load), .ref_ratio (ref_ratio), .ref_presc_sel (ref_presc_sel),
        .main_swallow (main_swallow), .main_count (main_count),
        .ref_ratio_low (ref_ratio_low), .main_count_low (main_count_low),
        .swallow_not_below_count (swallow_not_below_count)
    );

    // Behavioural model: the 19 most recent bits, oldest first.
    bit bitq[$];
    int m_ratio, m_presc, m_sw, m_cnt;
    bit m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            bitq = {};
            for (int i = 0; i < 19; i++) bitq.push_back(1'b0);
            m_ratio = 0; m_presc = 0; m_sw = 0; m_cnt = 0; m_prev = 0;
        end else begin
            if (ser_load) begin
                if (bitq[18]) begin
                    m_ratio = 0;
                    for (int i = 0; i < 14; i++) m_ratio += int'(bitq[3+i]) << i;
                    m_presc = int'(bitq[17]);
                end else begin
                    m_sw = 0; m_cnt = 0;
                    for (int i = 0; i < 7; i++)  m_sw  += int'(bitq[i]) << i;
                    for (int i = 0; i < 11; i++) m_cnt += int'(bitq[7+i]) << i;
                end
            end
            if (ser_clk && !m_prev) begin
                bitq.push_back(ser_data);
                void'(bitq.pop_front());
            end
            m_prev = ser_clk;
        end
    end

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison with the model (R6 R9 R10).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 R9 R10 model",
                  {ref_ratio, ref_presc_sel, main_swallow, main_count,
                   ref_ratio_low, main_count_low, swallow_not_below_count},
                  {14'(m_ratio), 1'(m_presc), 7'(m_sw), 11'(m_cnt),
                   m_ratio < 8, m_cnt < 16, m_sw >= m_cnt});
        end
    end

    task automatic send_bits(logic [31:0] val, int len, int hold);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ser_data = val[i];
            ser_clk = 1'b1;
            repeat (hold) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_ref(int ratio, bit presc, int hold);
        send_bits({16'd0, 1'b1, presc, 14'(ratio)}, 16, hold);
    endtask

    task automatic send_main(int a, int n);
        send_bits({13'd0, 1'b0, 11'(n), 7'(a)}, 19, 1);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ser_load = 1'b1;
        @(negedge clk);
        ser_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {ref_ratio, ref_presc_sel, main_swallow, main_count}, 0);
        check("R1 flags", {ref_ratio_low, main_count_low, swallow_not_below_count}, 3'b111);

        send_ref(1234, 1'b1, 1);
        check("R7 before load", ref_ratio, 0);
        load_pulse();
        check("R4 ratio", ref_ratio, 1234);
        check("R4 presc", ref_presc_sel, 1);
        check("R4 main untouched", main_count, 0);

        send_main(37, 1500);
        load_pulse();
        check("R5 swallow", main_swallow, 37);
        check("R5 count", main_count, 1500);
        check("R5 ref untouched", ref_ratio, 1234);

        send_main(5, 600);
        check("R7 hold swallow", main_swallow, 37);
        check("R7 hold count", main_count, 1500);
        load_pulse();
        check("R6 new count", main_count, 600);

        send_bits(32'h3F, 6, 1);
        send_ref(300, 1'b0, 1);
        load_pulse();
        check("R3 leading bits ratio", ref_ratio, 300);
        check("R3 leading bits presc", ref_presc_sel, 0);

        send_ref(9000, 1'b1, 3);
        load_pulse();
        check("R2 held clock ratio", ref_ratio, 9000);

        // R8: shift and load on the same edge.
        send_ref(4321, 1'b0, 1);
        @(negedge clk);
        ser_data = 1'b1; ser_clk = 1'b1; ser_load = 1'b1;
        @(negedge clk);
        ser_load = 1'b0; ser_clk = 1'b0;
        check("R8 pre-shift ratio", ref_ratio, 4321);
        check("R8 pre-shift presc", ref_presc_sel, 0);
        check("R8 main untouched", main_count, 600);

        // R9: load held high over several edges follows new bits.
        send_main(9, 700);
        @(negedge clk); ser_load = 1'b1;
        @(negedge clk);
        check("R9 first transfer", main_count, 700);
        send_main(11, 800);
        @(negedge clk); ser_load = 1'b0;
        check("R9 continued transfer", main_count, 800);

        // R10 range flags
        send_ref(7, 1'b0, 1); load_pulse();
        check("R10 ratio 7 low", ref_ratio_low, 1);
        send_ref(8, 1'b0, 1); load_pulse();
        check("R10 ratio 8 ok", ref_ratio_low, 0);
        send_main(3, 15); load_pulse();
        check("R10 count 15 low", main_count_low, 1);
        check("R10 a3 n15", swallow_not_below_count, 0);
        send_main(16, 16); load_pulse();
        check("R10 count 16 ok", main_count_low, 0);
        check("R10 a16 n16", swallow_not_below_count, 1);
        send_main(15, 16); load_pulse();
        check("R10 a15 n16", swallow_not_below_count, 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule